// File: doc/BRIEF.md
# Dual-Mode Modular Butterfly for Number Theoretic Transforms

This block is the arithmetic heart of a radix-2 number theoretic transform engine working on coefficients modulo the prime 3329. Each clock it can take two reduced coefficients, a reduced twiddle factor and a mode bit, and a fixed number of cycles later it returns two reduced coefficients. With the mode bit low it computes a decimation-in-time butterfly for the forward transform: the twiddle multiplies the second operand before the sum and difference. With the mode bit high it computes a decimation-in-frequency butterfly for the inverse transform: the sum and difference come first, and the difference is then multiplied by the twiddle.

Both modes share one modular multiplier. The multiplier's reduction method is fixed when the block is built. One choice is a Barrett reduction, which takes twiddles in plain form. The other is a Montgomery reduction with a radix of 2^16, which takes twiddles already multiplied by 2^16 modulo 3329. The surrounding engine handles address generation, coefficient storage, twiddle tables and the final scaling of an inverse transform.

Top module: `nttbf_core`

## Requirements
- R1: With `inv_mode` = 0, `res_x` equals (a + w·b) mod 3329 and `res_y` equals (a − w·b) mod 3329, where a, b and w are the values presented with that operand set.
- R2: With `inv_mode` = 1, `res_x` equals (a + b) mod 3329 and `res_y` equals ((a − b)·w) mod 3329.
- R3: Every result presented with `out_valid` high is below 3329, including when an addition reaches or passes the modulus or a subtraction goes below zero.
- R4: `out_valid` repeats `in_valid` exactly 5 clock edges later, in both modes, and the results for an operand set appear together with that pulse.
- R5: A new operand set is accepted on every clock edge with no stall, and a stream that mixes the two modes from one cycle to the next yields one correct result per input in input order.
- R6: In the Montgomery build (`REDUCTION` = RED_MONTGOMERY), a twiddle given as (w·65536) mod 3329 yields the same results as R1 and R2 with twiddle w.
- R7: While `rst_n` is low, and on the first edge after it rises, `out_valid`, `res_x` and `res_y` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set on the data inputs is valid this cycle |
| inv_mode | input | 1 | 0 = forward (decimation-in-time), 1 = inverse (decimation-in-frequency) |
| coef_a | input | COEF_W | First coefficient, below the modulus |
| coef_b | input | COEF_W | Second coefficient, below the modulus |
| twiddle | input | COEF_W | Twiddle factor, below the modulus (scaled by 2^16 in the Montgomery build) |
| out_valid | output | 1 | Results on `res_x` and `res_y` are valid |
| res_x | output | COEF_W | First result coefficient |
| res_y | output | COEF_W | Second result coefficient |

## Verification
The bench builds the block twice with the default 12-bit width and modulus 3329: once with Barrett reduction and once with Montgomery reduction. Both copies get the same coefficients and mode, and the Montgomery copy gets the twiddle pre-scaled by 2^16. This puts the two reduction paths and their final conditional subtractions side by side on the same operands. The extreme values 0 and 3328 drive both reductions to the top of their ranges. A long gap-free stream with random modes shows that the two modes line up in the shared pipeline.

// File: rtl/nttbf_pkg.sv
package nttbf_pkg;

   typedef enum logic [0:0] {
      RED_BARRETT    = 1'b0,
      RED_MONTGOMERY = 1'b1
   } red_e;

   // register stages inside the modular multiplier
   localparam int MUL_LAT  = 3;
   // input stage + multiplier + output stage
   localparam int PIPE_LAT = MUL_LAT + 2;

   // -q^{-1} mod 2^bits by Newton iteration (q odd)
   function automatic longint neg_inv_pow2(longint q, int bits);
      longint mask;
      longint inv;
      mask = (longint'(1) << bits) - 1;
      inv  = q;
      for (int i = 0; i < 6; i++) begin
         inv = (inv * (2 - q * inv)) & mask;
      end
      return (-inv) & mask;
   endfunction

endpackage

// File: rtl/nttbf_addsub.sv
module nttbf_addsub #(
   parameter int W = 12,
   parameter int Q = 3329
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] sum_mod,
   output logic [W-1:0] diff_mod
);

   localparam logic [W:0] QW = (W+1)'(Q);

   logic [W:0] sum_raw;
   logic [W:0] sum_red;
   logic [W:0] diff_red;

   always_comb begin
      sum_raw = {1'b0, op_a} + {1'b0, op_b};
      sum_red = (sum_raw >= QW) ? (sum_raw - QW) : sum_raw;
      if (op_a >= op_b) begin
         diff_red = {1'b0, op_a} - {1'b0, op_b};
      end else begin
         diff_red = {1'b0, op_a} + QW - {1'b0, op_b};
      end
   end

   assign sum_mod  = sum_red[W-1:0];
   assign diff_mod = diff_red[W-1:0];

endmodule

// File: rtl/nttbf_modmul.sv
module nttbf_modmul #(
   parameter int              W   = 12,
   parameter int              Q   = 3329,
   parameter nttbf_pkg::red_e RED = nttbf_pkg::RED_BARRETT,
   parameter int              MB  = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] op_x,
   input  logic [W-1:0] op_w,
   output logic [W-1:0] prod
);

   localparam int PW = 2 * W;

   // stage A: full product
   logic [PW-1:0] p_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_a <= '0;
      end else begin
         p_a <= {{W{1'b0}}, op_x} * {{W{1'b0}}, op_w};
      end
   end

   if (RED == nttbf_pkg::RED_BARRETT) begin : g_barrett
      localparam int              BK   = PW;
      localparam longint          BM_L = (longint'(1) << BK) / longint'(Q);
      localparam int              BMW  = $clog2(BM_L + 1);
      localparam logic [BMW-1:0]  BM   = BMW'(BM_L);
      localparam int              RW   = W + 2;
      localparam logic [RW-1:0]   Q1   = RW'(Q);
      localparam logic [RW-1:0]   Q2   = RW'(2 * Q);

      logic [PW+BMW-1:0] mp;
      logic [PW-1:0]     p_b;
      logic [BMW-1:0]    qh_b;
      logic [PW+BMW-1:0] qq;
      logic [PW-1:0]     r_full;
      logic [RW-1:0]     r_raw;
      logic [RW-1:0]     r_red;

      assign mp = {{BMW{1'b0}}, p_a} * {{PW{1'b0}}, BM};

      // stage B: quotient estimate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_b  <= '0;
            qh_b <= '0;
         end else begin
            p_b  <= p_a;
            qh_b <= mp[PW+BMW-1:BK];
         end
      end

      always_comb begin
         qq     = {{PW{1'b0}}, qh_b} * (PW+BMW)'(Q);
         r_full = p_b - qq[PW-1:0];
         r_raw  = r_full[RW-1:0];
         if (r_raw >= Q2) begin
            r_red = r_raw - Q2;
         end else if (r_raw >= Q1) begin
            r_red = r_raw - Q1;
         end else begin
            r_red = r_raw;
         end
      end

      // stage C: reduced result
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod <= '0;
         end else begin
            prod <= r_red[W-1:0];
         end
      end
   end else begin : g_montgomery
      localparam logic [MB-1:0] QINV = MB'(nttbf_pkg::neg_inv_pow2(longint'(Q), MB));
      localparam int            SW   = ((MB + W > PW) ? (MB + W) : PW) + 1;
      localparam int            TW   = SW - MB;
      localparam logic [TW-1:0] QT   = TW'(Q);

      logic [2*MB-1:0] mq_full;
      logic [PW-1:0]   p_b;
      logic [MB-1:0]   m_b;
      logic [SW-1:0]   acc;
      logic [TW-1:0]   t_raw;
      logic [TW-1:0]   t_red;

      assign mq_full = {{MB{1'b0}}, p_a[MB-1:0]} * {{MB{1'b0}}, QINV};

      // stage B: Montgomery factor
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_b <= '0;
            m_b <= '0;
         end else begin
            p_b <= p_a;
            m_b <= mq_full[MB-1:0];
         end
      end

      always_comb begin
         acc   = SW'(p_b) + ({{(SW-MB){1'b0}}, m_b} * SW'(Q));
         t_raw = acc[SW-1:MB];
         t_red = (t_raw >= QT) ? (t_raw - QT) : t_raw;
      end

      // stage C: reduced result
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod <= '0;
         end else begin
            prod <= t_red[W-1:0];
         end
      end
   end

endmodule

// File: rtl/nttbf_core.sv
module nttbf_core #(
   parameter int              COEF_W    = 12,
   parameter int              MODULUS   = 3329,
   parameter nttbf_pkg::red_e REDUCTION = nttbf_pkg::RED_BARRETT,
   parameter int              MONT_BITS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              inv_mode,
   input  logic [COEF_W-1:0] coef_a,
   input  logic [COEF_W-1:0] coef_b,
   input  logic [COEF_W-1:0] twiddle,
   output logic              out_valid,
   output logic [COEF_W-1:0] res_x,
   output logic [COEF_W-1:0] res_y
);

   localparam int W    = COEF_W;
   localparam int ML   = nttbf_pkg::MUL_LAT;
   localparam int LAST = ML - 1;

   // elaboration-time parameter checks
   if (MODULUS < 3 || MODULUS >= (2 ** COEF_W)) begin : g_chk_mod
      $error("nttbf_core: MODULUS must lie in [3, 2**COEF_W)");
   end
   if (COEF_W < 2 || COEF_W > 30) begin : g_chk_w
      $error("nttbf_core: COEF_W out of supported range");
   end
   if (REDUCTION == nttbf_pkg::RED_MONTGOMERY) begin : g_chk_mont
      if ((MODULUS % 2) == 0) begin : g_odd
         $error("nttbf_core: Montgomery reduction needs an odd modulus");
      end
      if (MONT_BITS <= COEF_W || MONT_BITS > 2 * COEF_W || MONT_BITS > 30) begin : g_bits
         $error("nttbf_core: MONT_BITS must lie in (COEF_W, 2*COEF_W]");
      end
   end

   // ---------------- input stage: optional sum/difference ----------------
   logic [W-1:0] pre_sum;
   logic [W-1:0] pre_diff;

   nttbf_addsub #(.W(W), .Q(MODULUS)) u_pre (
      .op_a     (coef_a),
      .op_b     (coef_b),
      .sum_mod  (pre_sum),
      .diff_mod (pre_diff)
   );

   logic         s1_v;
   logic         s1_gs;
   logic [W-1:0] s1_u;
   logic [W-1:0] s1_m;
   logic [W-1:0] s1_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         s1_gs <= 1'b0;
         s1_u  <= '0;
         s1_m  <= '0;
         s1_w  <= '0;
      end else begin
         s1_v  <= in_valid;
         s1_gs <= inv_mode;
         s1_u  <= inv_mode ? pre_sum  : coef_a;
         s1_m  <= inv_mode ? pre_diff : coef_b;
         s1_w  <= twiddle;
      end
   end

   // ---------------- shared modular multiplier ----------------
   logic [W-1:0] mul_p;

   nttbf_modmul #(
      .W   (W),
      .Q   (MODULUS),
      .RED (REDUCTION),
      .MB  (MONT_BITS)
   ) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .op_x  (s1_m),
      .op_w  (s1_w),
      .prod  (mul_p)
   );

   // ---------------- side band alignment with the multiplier ----------------
   logic [ML-1:0] v_d;
   logic [ML-1:0] gs_d;
   logic [W-1:0]  u_d [ML];

   for (genvar i = 0; i < ML; i++) begin : g_dly
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_d[i]  <= 1'b0;
               gs_d[i] <= 1'b0;
               u_d[i]  <= '0;
            end else begin
               v_d[i]  <= s1_v;
               gs_d[i] <= s1_gs;
               u_d[i]  <= s1_u;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_d[i]  <= 1'b0;
               gs_d[i] <= 1'b0;
               u_d[i]  <= '0;
            end else begin
               v_d[i]  <= v_d[i-1];
               gs_d[i] <= gs_d[i-1];
               u_d[i]  <= u_d[i-1];
            end
         end
      end
   end

   // ---------------- output stage: optional sum/difference ----------------
   logic [W-1:0] post_sum;
   logic [W-1:0] post_diff;

   nttbf_addsub #(.W(W), .Q(MODULUS)) u_post (
      .op_a     (u_d[LAST]),
      .op_b     (mul_p),
      .sum_mod  (post_sum),
      .diff_mod (post_diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_x     <= '0;
         res_y     <= '0;
      end else begin
         out_valid <= v_d[LAST];
         res_x     <= gs_d[LAST] ? u_d[LAST] : post_sum;
         res_y     <= gs_d[LAST] ? mul_p     : post_diff;
      end
   end

endmodule

// File: rtl/nttbf_chk.sv
module nttbf_chk #(
   parameter int COEF_W  = 12,
   parameter int MODULUS = 3329
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              inv_mode,
   input logic [COEF_W-1:0] coef_a,
   input logic [COEF_W-1:0] coef_b,
   input logic [COEF_W-1:0] twiddle,
   input logic              out_valid,
   input logic [COEF_W-1:0] res_x,
   input logic [COEF_W-1:0] res_y
);

   localparam int L = nttbf_pkg::PIPE_LAT;

   // input history, cleared by reset like the design pipeline
   logic [L-1:0]      h_v;
   logic [L-1:0]      h_gs;
   logic [L-1:0]      h_bz;
   logic [L-1:0]      h_eq;
   logic [COEF_W-1:0] h_a [L];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_v  <= '0;
         h_gs <= '0;
         h_bz <= '0;
         h_eq <= '0;
         for (int i = 0; i < L; i++) h_a[i] <= '0;
      end else begin
         h_v  <= {h_v[L-2:0],  in_valid};
         h_gs <= {h_gs[L-2:0], inv_mode};
         h_bz <= {h_bz[L-2:0], (coef_b == '0)};
         h_eq <= {h_eq[L-2:0], (coef_a == coef_b)};
         h_a[0] <= coef_a;
         for (int i = 1; i < L; i++) h_a[i] <= h_a[i-1];
      end
   end

   logic unused_tw;
   assign unused_tw = ^twiddle;

   assert_valid_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == h_v[L-1]);

   assert_x_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (res_x < COEF_W'(MODULUS)));

   assert_y_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (res_y < COEF_W'(MODULUS)));

   assert_reset_clear_R7: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && res_x == '0 && res_y == '0));

   assert_fwd_zero_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (h_v[L-1] && !h_gs[L-1] && h_bz[L-1]) |-> (res_x == h_a[L-1] && res_y == h_a[L-1]));

   assert_inv_equal_ops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_v[L-1] && h_gs[L-1] && h_eq[L-1]) |-> (res_y == '0));

endmodule

bind nttbf_core nttbf_chk #(.COEF_W(COEF_W), .MODULUS(MODULUS)) i_nttbf_chk (.*);

// File: tb/test_nttbf_core.sv
`timescale 1ns/1ps
module test_nttbf_core;

   localparam int W   = 12;
   localparam int Q   = 3329;
   localparam int LAT = 5;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n;
   logic         in_valid;
   logic         inv_mode;
   logic [W-1:0] coef_a;
   logic [W-1:0] coef_b;
   logic [W-1:0] tw_bar;
   logic [W-1:0] tw_mon;
   logic         ov_bar, ov_mon;
   logic [W-1:0] rx_bar, ry_bar, rx_mon, ry_mon;

   nttbf_core #(.COEF_W(W), .MODULUS(Q), .REDUCTION(nttbf_pkg::RED_BARRETT)) i_nttbf_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
      .coef_a(coef_a), .coef_b(coef_b), .twiddle(tw_bar),
      .out_valid(ov_bar), .res_x(rx_bar), .res_y(ry_bar));

   nttbf_core #(.COEF_W(W), .MODULUS(Q), .REDUCTION(nttbf_pkg::RED_MONTGOMERY),
                .MONT_BITS(16)) i_nttbf_core_mont (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
      .coef_a(coef_a), .coef_b(coef_b), .twiddle(tw_mon),
      .out_valid(ov_mon), .res_x(rx_mon), .res_y(ry_mon));

   typedef struct {
      int    x;
      int    y;
      int    issue;
      string req;
   } exp_t;

   exp_t q_bar[$];
   exp_t q_mon[$];

   int cyc    = 0;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic int md(input int v);
      int r;
      r = v % Q;
      return (r < 0) ? r + Q : r;
   endfunction

   task automatic drive(input bit gs, input int a, input int b, input int w);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      inv_mode = gs;
      coef_a   = W'(a);
      coef_b   = W'(b);
      tw_bar   = W'(w);
      tw_mon   = W'((w * 65536) % Q);
      if (gs) begin
         e.x   = md(a + b);
         e.y   = md((a - b) * w);
         e.req = "R2";
      end else begin
         e.x   = md(a + w * b);
         e.y   = md(a - w * b);
         e.req = "R1";
      end
      e.issue = cyc;
      q_bar.push_back(e);
      q_mon.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && !done) begin
         if (ov_bar) begin
            if (q_bar.size() == 0) begin
               check(1'b0, "R4", "unexpected valid (Barrett)", 1, 0);
            end else begin
               e = q_bar.pop_front();
               check(int'(rx_bar) == e.x, e.req, "res_x Barrett", int'(rx_bar), e.x);
               check(int'(ry_bar) == e.y, e.req, "res_y Barrett", int'(ry_bar), e.y);
               check(cyc - e.issue == LAT, "R4", "latency Barrett", cyc - e.issue, LAT);
               check(int'(rx_bar) < Q && int'(ry_bar) < Q, "R3", "range Barrett",
                     int'(rx_bar) > int'(ry_bar) ? int'(rx_bar) : int'(ry_bar), Q - 1);
            end
         end
         if (ov_mon) begin
            if (q_mon.size() == 0) begin
               check(1'b0, "R6", "unexpected valid (Montgomery)", 1, 0);
            end else begin
               e = q_mon.pop_front();
               check(int'(rx_mon) == e.x, "R6", {"res_x Montgomery ", e.req}, int'(rx_mon), e.x);
               check(int'(ry_mon) == e.y, "R6", {"res_y Montgomery ", e.req}, int'(ry_mon), e.y);
               check(cyc - e.issue == LAT, "R4", "latency Montgomery", cyc - e.issue, LAT);
               check(int'(rx_mon) < Q && int'(ry_mon) < Q, "R3", "range Montgomery",
                     int'(rx_mon) > int'(ry_mon) ? int'(rx_mon) : int'(ry_mon), Q - 1);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      if (cyc == 20000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
         finish_run();
      end
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b1;
      inv_mode = 1'b0;
      coef_a   = 12'd5;
      coef_b   = 12'd7;
      tw_bar   = 12'd9;
      tw_mon   = 12'd9;
      repeat (4) @(negedge clk);
      // R7: outputs cleared while reset is held, even with valid inputs
      check(!ov_bar && rx_bar == 0 && ry_bar == 0, "R7", "reset state Barrett",
            int'(ov_bar) + int'(rx_bar) + int'(ry_bar), 0);
      check(!ov_mon && rx_mon == 0 && ry_mon == 0, "R7", "reset state Montgomery",
            int'(ov_mon) + int'(rx_mon) + int'(ry_mon), 0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      check(!ov_bar && !ov_mon, "R7", "valid after reset release", int'(ov_bar | ov_mon), 0);
      idle(2);

      // R1 forward corners
      drive(1'b0, 0, 0, 0);
      drive(1'b0, 3328, 3328, 3328);
      drive(1'b0, 0, 1, 1);          // subtraction wraps below zero (R3)
      drive(1'b0, 3328, 1, 1);       // addition reaches the modulus (R3)
      drive(1'b0, 1234, 0, 2000);
      drive(1'b0, 17, 3328, 1);
      // R2 inverse corners
      drive(1'b1, 0, 0, 0);
      drive(1'b1, 3328, 3328, 3328);
      drive(1'b1, 0, 3328, 1);
      drive(1'b1, 3328, 1, 3328);
      drive(1'b1, 100, 100, 777);
      drive(1'b1, 1, 2, 17);
      idle(LAT + 2);
      // R4: no pulse with no input
      check(!ov_bar && !ov_mon, "R4", "idle valid low", int'(ov_bar | ov_mon), 0);

      // R5: gap-free stream with modes mixed cycle by cycle
      for (int i = 0; i < 400; i++) begin
         drive(1'($urandom_range(1)), int'($urandom_range(Q - 1)),
               int'($urandom_range(Q - 1)), int'($urandom_range(Q - 1)));
      end
      // single-cycle bubbles between operations
      for (int i = 0; i < 40; i++) begin
         drive(1'(i % 2), int'($urandom_range(Q - 1)), int'($urandom_range(Q - 1)),
               int'($urandom_range(Q - 1)));
         idle(1);
      end
      idle(LAT + 3);
      check(q_bar.size() == 0, "R5", "pending Barrett results", q_bar.size(), 0);
      check(q_mon.size() == 0, "R5", "pending Montgomery results", q_mon.size(), 0);
      check(!ov_bar && !ov_mon, "R4", "drained valid low", int'(ov_bar | ov_mon), 0);
      finish_run();
   end

endmodule